// File: doc/BRIEF.md
# Return Address Stack with Combined Pop-Push

This block predicts return targets for a fetch unit that handles one instruction per cycle. A small decoder looks at each 16-bit or 32-bit instruction and sorts it into:

- a two-bit jump kind;
- a call flag;
- a flag that says the instruction consumes a return address.

The stack then acts on those flags:

- A call pushes the address of the next sequential instruction.
- A return pops the stack and presents the popped address as the predicted target in that same cycle.

An indirect jump that reads one link register and writes the other is a return and a call at once. The block handles it in a single cycle:

- It presents the current top entry as the target.
- It overwrites that entry with the fresh return address.
- The stack depth stays the same.

The stack is a circular buffer. When it is full, a push overwrites the oldest entry. A flush input empties it in one cycle.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty, `tgt_valid` is 0, and the first return seen produces no valid target.
- R2: `cls_kind` encodes the jump kind as 2'b00 not a control transfer, 2'b01 conditional branch, 2'b10 direct jump (jal, c.j), 2'b11 indirect jump (jalr, c.jr, c.jalr).
- R3: `cls_call` is 1 when the destination register is x1 or x5 and the instruction is either an uncompressed direct jump or any indirect jump. c.jalr counts as writing x1. Compressed direct jumps are never calls.
- R4: `cls_has_ret` is 1 for an indirect jump whose source register is x1 or x5 and which is not a call. The source register is bits 19:15 for 32-bit forms and bits 11:7 for compressed forms.
- R5: An indirect jump whose source and destination are both link registers, and are different registers, sets both `cls_call` and `cls_has_ret`. An indirect jump with the same link register in both fields is a call only.
- R6: A valid call pushes `in_pc` + 4 for a 32-bit instruction, or `in_pc` + 2 for a compressed one (low bits 2'b11 mean 32-bit).
- R7: A valid return with a non-empty stack pops the most recent entry. It asserts `tgt_valid` with that entry on `tgt_addr` in the same cycle only. Entries come out in last-in first-out order.
- R8: A valid return-call with a non-empty stack outputs the top entry and replaces it with the new return address, leaving the depth unchanged. On an empty stack it only pushes.
- R9: The stack holds 16 entries. A push when full overwrites the oldest entry, so 17 pushes followed by pops return the newest 16 and then no valid target.
- R10: A return on an empty stack gives `tgt_valid` 0 and leaves the stack usable: a later push and pop return the pushed address.
- R11: `flush` empties the stack in one cycle and takes priority over any instruction in the same cycle.
- R12: With `in_valid` 0, the stack is not changed and `tgt_valid` stays 0, whatever the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the stack |
| in_valid | input | 1 | Instruction fields are valid this cycle |
| in_instr | input | 32 | Instruction bits; compressed forms in bits 15:0 |
| in_pc | input | ADDR_W | Address of the instruction |
| tgt_valid | output | 1 | Predicted return target is valid |
| tgt_addr | output | ADDR_W | Predicted return target |
| cls_kind | output | 2 | Decoded jump kind |
| cls_call | output | 1 | Decoded call flag |
| cls_has_ret | output | 1 | Decoded return-or-return-call flag |

## Verification
A wrong pointer or count is invisible until the next return. It then shows as a wrong `tgt_addr` or a wrong `tgt_valid` in the very cycle the return is presented. The tests therefore follow each push pattern with a full drain, checking every popped address and the invalid result once the stack is empty.

The return-call case is checked in two cycles:

- the cycle of the return-call, for the old top entry;
- the following return, for the overwritten entry.

Overflow and flush are checked in the same way, by the addresses and the valid flag that come out of the drain afterwards.

// File: rtl/ras_pkg.sv
// Package: shared jump-kind code and link-register test for the
// return address stack. Assumes a RISC-V style register numbering.
package ras_pkg;

    typedef enum logic [1:0] {
        JK_NONE   = 2'b00,
        JK_BRANCH = 2'b01,
        JK_JAL    = 2'b10,
        JK_JALR   = 2'b11
    } jkind_e;

    // True for the two registers used as link registers (x1, x5).
    function automatic logic is_link(input logic [4:0] r);
        return (r == 5'd1) || (r == 5'd5);
    endfunction

endpackage

// File: rtl/ras_classify.sv
// Module: ras_classify
// Purely combinational decoder. Sorts one instruction into a jump kind,
// a call flag and a has-return flag (return or return-call).
// Assumes compressed forms sit in bits 15:0 with bits 1:0 != 2'b11.
module ras_classify
    import ras_pkg::*;
(
    input  logic [31:0] instr,
    output jkind_e      kind,
    output logic        is_rvc,
    output logic        is_call,
    output logic        has_ret
);

    logic [4:0] rd;
    logic [4:0] rs;
    logic       ret_only;
    logic       ret_call;

    // Decode jump kind and register fields for both encodings.
    always_comb begin
        kind   = JK_NONE;
        rd     = 5'd0;
        rs     = 5'd0;
        is_rvc = (instr[1:0] != 2'b11);
        if (is_rvc) begin
            if (instr[1:0] == 2'b01 && instr[15:13] == 3'b101) begin
                kind = JK_JAL;
            end else if (instr[1:0] == 2'b01 && instr[15:14] == 2'b11) begin
                kind = JK_BRANCH;
            end else if (instr[1:0] == 2'b10 && instr[15:13] == 3'b100 &&
                         instr[6:2] == 5'd0 && instr[11:7] != 5'd0) begin
                kind = JK_JALR;
            end
            rd = instr[12] ? 5'd1 : 5'd0;
            rs = (kind == JK_JAL) ? 5'd0 : instr[11:7];
        end else begin
            if (instr[6:0] == 7'b1101111) begin
                kind = JK_JAL;
            end else if (instr[6:0] == 7'b1100111 && instr[14:12] == 3'b000) begin
                kind = JK_JALR;
            end else if (instr[6:0] == 7'b1100011) begin
                kind = JK_BRANCH;
            end
            rd = instr[11:7];
            rs = instr[19:15];
        end
    end

    // Derive call, return and return-call flags from the fields.
    always_comb begin
        is_call  = ((kind == JK_JAL && !is_rvc) || kind == JK_JALR) && is_link(rd);
        ret_only = (kind == JK_JALR) && is_link(rs) && !is_call;
        ret_call = (kind == JK_JALR) && is_link(rs) && is_link(rd) && (rs != rd);
        has_ret  = ret_only || ret_call;
    end

endmodule

// File: rtl/ras_stack.sv
// Module: ras_stack
// Circular return-address storage with a top pointer and an occupancy
// count. Push when full overwrites the oldest entry; pop when empty is
// ignored; push and pop together replace the top entry in place.
// Assumes push/pop are already qualified by the caller.
module ras_stack #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              top_valid,
    output logic [ADDR_W-1:0] top_addr
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr;      // next free slot
    logic [CNT_W-1:0]  count;
    logic [PTR_W-1:0]  top_idx;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST : p - PTR_W'(1);
    endfunction

    // Locate the newest entry and present it.
    always_comb begin
        top_idx   = ptr_dec(ptr);
        top_valid = (count != '0);
        top_addr  = mem[top_idx];
    end

    // Update storage, pointer and count for push, pop or both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr   <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            ptr   <= '0;
            count <= '0;
        end else if (push && pop && count != '0) begin
            mem[top_idx] <= push_addr;
        end else if (push) begin
            mem[ptr] <= push_addr;
            ptr      <= ptr_inc(ptr);
            if (count != FULL) count <= count + CNT_W'(1);
        end else if (pop && count != '0) begin
            ptr   <= ptr_dec(ptr);
            count <= count - CNT_W'(1);
        end
    end

    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    p_retcall_keeps_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push && pop && count != '0) |=> (count == $past(count)));

    p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push && !pop && count != FULL) |=> (count == $past(count) + CNT_W'(1)));

    p_empty_pop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && pop && !push && count == '0) |=> ($stable(ptr) && count == '0));

endmodule

// File: rtl/ras_predictor.sv
// Module: ras_predictor (top)
// Single-instruction return address predictor: classifies the incoming
// instruction, pushes the next sequential address on calls, pops on
// returns and does both at once for a return-call. The target output is
// combinational from stored state and valid only in the return cycle.
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [ADDR_W-1:0] in_pc,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [1:0]        cls_kind,
    output logic              cls_call,
    output logic              cls_has_ret
);

    jkind_e            kind;
    logic              is_rvc;
    logic              is_call;
    logic              has_ret;
    logic              do_push;
    logic              do_pop;
    logic [ADDR_W-1:0] ret_addr;
    logic              top_valid;
    logic [ADDR_W-1:0] top_addr;

    ras_classify u_cls (
        .instr   (in_instr),
        .kind    (kind),
        .is_rvc  (is_rvc),
        .is_call (is_call),
        .has_ret (has_ret)
    );

    // Qualify stack actions and form the sequential return address.
    always_comb begin
        do_push  = in_valid && is_call;
        do_pop   = in_valid && has_ret;
        ret_addr = in_pc + (is_rvc ? ADDR_W'(2) : ADDR_W'(4));
    end

    ras_stack #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (do_push),
        .pop       (do_pop),
        .push_addr (ret_addr),
        .top_valid (top_valid),
        .top_addr  (top_addr)
    );

    // Drive the prediction and classifier outputs.
    always_comb begin
        tgt_valid   = do_pop && top_valid;
        tgt_addr    = top_addr;
        cls_kind    = kind;
        cls_call    = is_call;
        cls_has_ret = has_ret;
    end

    p_target_on_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (in_valid && cls_has_ret));

    p_hasret_is_jalr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cls_has_ret |-> (cls_kind == 2'b11));

    p_no_action_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !tgt_valid);

endmodule

// File: tb/sim_ras_predictor.sv
module sim_ras_predictor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = 32'h0000_0013;
    logic [31:0] in_pc = '0;
    logic        tgt_valid;
    logic [31:0] tgt_addr;
    logic [1:0]  cls_kind;
    logic        cls_call;
    logic        cls_has_ret;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ras_predictor #(.DEPTH(16), .ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_instr(in_instr), .in_pc(in_pc), .tgt_valid(tgt_valid),
        .tgt_addr(tgt_addr), .cls_kind(cls_kind), .cls_call(cls_call),
        .cls_has_ret(cls_has_ret)
    );

    localparam logic [31:0] JAL_X1  = 32'h0000_00EF;
    localparam logic [31:0] RET_X1  = 32'h0000_8067;  // jalr x0, x1
    localparam logic [31:0] RC_1_5  = 32'h0000_82E7;  // jalr x5, x1
    localparam logic [31:0] CJALR1  = 32'h0000_9082;
    localparam logic [31:0] CJALR5  = 32'h0000_9282;

    // {instr, kind, call, has_ret}
    localparam logic [35:0] VEC [18] = '{
        {32'h0000_0013, 2'd0, 1'b0, 1'b0},
        {32'h0000_0063, 2'd1, 1'b0, 1'b0},
        {32'h0000_00EF, 2'd2, 1'b1, 1'b0},
        {32'h0000_006F, 2'd2, 1'b0, 1'b0},
        {32'h0000_02EF, 2'd2, 1'b1, 1'b0},
        {32'h0000_8067, 2'd3, 1'b0, 1'b1},
        {32'h0000_80E7, 2'd3, 1'b1, 1'b0},
        {32'h0002_80E7, 2'd3, 1'b1, 1'b1},
        {32'h0000_82E7, 2'd3, 1'b1, 1'b1},
        {32'h0003_0067, 2'd3, 1'b0, 1'b0},
        {32'h0000_8167, 2'd3, 1'b0, 1'b1},
        {32'h0000_A001, 2'd2, 1'b0, 1'b0},
        {32'h0000_8082, 2'd3, 1'b0, 1'b1},
        {32'h0000_9082, 2'd3, 1'b1, 1'b0},
        {32'h0000_9282, 2'd3, 1'b1, 1'b1},
        {32'h0000_C001, 2'd1, 1'b0, 1'b0},
        {32'h0000_8086, 2'd0, 1'b0, 1'b0},
        {32'h0002_82E7, 2'd3, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] ins,
                         input logic [31:0] pc, input logic fl);
        @(negedge clk);
        in_valid = v; in_instr = ins; in_pc = pc; flush = fl;
        #1;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(0, 32'h0000_0013, 0, 0);
        chk("R1 idle valid", {31'b0, tgt_valid}, 0);
        drive(1, RET_X1, 0, 0);
        chk("R1 R10 empty return", {31'b0, tgt_valid}, 0);

        // Classifier table, in_valid low (R2..R5, R12)
        for (int i = 0; i < 18; i++) begin
            drive(0, VEC[i][35:4], 32'h40, 0);
            chk($sformatf("R2 kind row %0d", i), {30'b0, cls_kind}, {30'b0, VEC[i][3:2]});
            chk($sformatf("R3 call row %0d", i), {31'b0, cls_call}, {31'b0, VEC[i][1]});
            chk($sformatf("R4 R5 has_ret row %0d", i), {31'b0, cls_has_ret}, {31'b0, VEC[i][0]});
            chk($sformatf("R12 idle row %0d", i), {31'b0, tgt_valid}, 0);
        end

        // Push 32-bit and compressed calls, pop LIFO (R6, R7, R10)
        drive(1, JAL_X1, 32'h1000, 0);
        drive(1, CJALR1, 32'h2000, 0);
        drive(1, RET_X1, 0, 0);
        chk("R6 R7 pop compressed valid", {31'b0, tgt_valid}, 1);
        chk("R6 R7 pop compressed addr", tgt_addr, 32'h2002);
        drive(0, RET_X1, 0, 0);
        chk("R7 valid only in return cycle", {31'b0, tgt_valid}, 0);
        drive(1, RET_X1, 0, 0);
        chk("R6 R7 pop 32-bit valid", {31'b0, tgt_valid}, 1);
        chk("R6 R7 pop 32-bit addr", tgt_addr, 32'h1004);
        drive(1, RET_X1, 0, 0);
        chk("R10 pop empty", {31'b0, tgt_valid}, 0);
        drive(1, JAL_X1, 32'h3000, 0);
        drive(1, RET_X1, 0, 0);
        chk("R10 usable after empty pop", tgt_addr, 32'h3004);
        chk("R10 usable valid", {31'b0, tgt_valid}, 1);

        // Return-call (R8)
        drive(1, JAL_X1, 32'h100, 0);
        drive(1, JAL_X1, 32'h200, 0);
        drive(1, RC_1_5, 32'h300, 0);
        chk("R8 retcall valid", {31'b0, tgt_valid}, 1);
        chk("R8 retcall old top", tgt_addr, 32'h204);
        drive(1, RET_X1, 0, 0);
        chk("R8 replaced top", tgt_addr, 32'h304);
        drive(1, RET_X1, 0, 0);
        chk("R8 depth unchanged", tgt_addr, 32'h104);
        drive(1, RET_X1, 0, 0);
        chk("R8 drained", {31'b0, tgt_valid}, 0);
        drive(1, CJALR5, 32'h400, 0);
        chk("R8 retcall empty valid", {31'b0, tgt_valid}, 0);
        drive(1, RET_X1, 0, 0);
        chk("R8 retcall empty pushed", tgt_addr, 32'h402);
        drive(1, RET_X1, 0, 0);
        chk("R8 retcall empty drained", {31'b0, tgt_valid}, 0);

        // Overflow (R9)
        for (int i = 0; i < 17; i++) drive(1, JAL_X1, 32'h1000 + 32'(i) * 16, 0);
        for (int k = 16; k >= 1; k--) begin
            drive(1, RET_X1, 0, 0);
            chk($sformatf("R9 overflow pop %0d addr", k), tgt_addr, 32'h1004 + 32'(k) * 16);
            chk($sformatf("R9 overflow pop %0d valid", k), {31'b0, tgt_valid}, 1);
        end
        drive(1, RET_X1, 0, 0);
        chk("R9 oldest overwritten", {31'b0, tgt_valid}, 0);

        // Flush with priority (R11)
        drive(1, JAL_X1, 32'h700, 0);
        drive(1, JAL_X1, 32'h800, 0);
        drive(1, JAL_X1, 32'h900, 1);
        drive(1, RET_X1, 0, 0);
        chk("R11 flush empties", {31'b0, tgt_valid}, 0);

        // in_valid low has no effect (R12)
        drive(1, JAL_X1, 32'h500, 0);
        drive(0, RET_X1, 0, 0);
        chk("R12 idle return no target", {31'b0, tgt_valid}, 0);
        drive(0, JAL_X1, 32'h600, 0);
        drive(1, RET_X1, 0, 0);
        chk("R12 stack untouched", tgt_addr, 32'h504);
        drive(1, RET_X1, 0, 0);
        chk("R12 no idle push", {31'b0, tgt_valid}, 0);

        drive(0, 32'h0000_0013, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule